// File: doc/BRIEF.md
# Triggered Circular Buffer Controller

This block manages the sample storage of one detector channel during a bunch train. Two ring pointers run at the same time. One advances on a fast sampling tick and the other on a slow one. Each pointer addresses a ring of sixteen slots, and the rings belong to the storage pair that is currently active. The analog sampling cells take their write addresses, write strobes and pair selection from this block.

A hit is declared when the digitized slow-shaper values of the channel and its two neighbours add up to more than a programmable threshold. A hit freezes the active pair and records where both pointers stood, so that the pair can later be read back oldest sample first. Writing then moves on to the next free pair. When every pair is frozen, further hits are dropped and a sticky overflow flag is raised.

When the train ends, acquisition stops and the block walks through the frozen pairs. It presents each stored slot to a single-slope converter. A ramp counter sweeps the full code range once per slot, and the code is taken on the first cycle that the channel's comparator reports a crossing. Each result leaves with its pair, ring and slot address.

Top module: `pulse_store_ctrl`

## Requirements
- R1: After reset the block is idle: `acquiring`, `overflow` and `rd_busy` are 0, and both pointers and `wr_pair` are 0. An accepted `train_start` sets `acquiring` in the next cycle and clears both pointers, all frozen pairs, the re-arm state and `overflow`. A `train_start` that arrives while `rd_busy` is 1 has no effect.
- R2: While acquiring, each cycle with `fast_tick` advances `fast_wptr` by one, and each cycle with `slow_tick` advances `slow_wptr` by one. Both pointers wrap from DEPTH-1 to 0. `fast_we`/`slow_we` equal the tick while acquiring and a pair is active; otherwise they are 0.
- R3: A hit is evaluated only in a cycle with `slow_tick`. The unsigned sum `nb_lo + own_val + nb_hi` must be strictly greater than `thresh`; a sum equal to `thresh` is not a hit.
- R4: After a hit, no further hit is accepted until a `slow_tick` cycle sees a sum at or below `thresh`.
- R5: An accepted hit advances `wr_pair` by one in the next cycle. Pairs are taken in index order 0, 1, 2, ... The frozen pair keeps the pointer values that result after that cycle's ticks.
- R6: A hit that arrives when all NPAIR pairs are frozen is dropped and sets `overflow`. `overflow` stays set until the next accepted `train_start`. While it is set, both write strobes are 0.
- R7: Outside the train window, hits and ticks are ignored: pointers, `wr_pair` and `overflow` do not change.
- R8: A `train_end` during acquisition stops acquisition and starts readout. Readout covers pairs 0 up to the last frozen pair. Within each pair, the fast ring (`rd_ring`=0) comes before the slow ring (`rd_ring`=1). Slot j of a ring is read at address (recorded pointer + j) mod DEPTH.
- R9: Each slot takes 2^RW cycles while `ramp_code` counts 0 to 2^RW-1. The result is the `ramp_code` value in the first cycle where `cmp_out` is 1, or 2^RW-1 if `cmp_out` never goes high.
- R10: `conv_valid` pulses in the cycle after the ramp's last step, together with `conv_code`, `conv_pair`, `conv_ring` and `conv_addr`. `rd_done` pulses together with the last result. If no pair is frozen, `rd_done` pulses in the cycle after `train_end` and no readout takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start | input | 1 | Start of bunch train (one-cycle pulse) |
| train_end | input | 1 | End of bunch train (one-cycle pulse) |
| fast_tick | input | 1 | Fast sampler step |
| slow_tick | input | 1 | Slow sampler step and trigger evaluation |
| nb_lo | input | VW | Digitized slow value, lower neighbour |
| own_val | input | VW | Digitized slow value, this channel |
| nb_hi | input | VW | Digitized slow value, upper neighbour |
| thresh | input | VW+2 | Trigger threshold on the three-channel sum |
| cmp_out | input | 1 | Comparator output during conversion |
| fast_wptr | output | log2(DEPTH) | Fast ring write slot |
| slow_wptr | output | log2(DEPTH) | Slow ring write slot |
| fast_we | output | 1 | Fast sample write strobe |
| slow_we | output | 1 | Slow sample write strobe |
| wr_pair | output | log2(NPAIR) | Pair being written |
| overflow | output | 1 | Hit dropped for lack of a free pair |
| acquiring | output | 1 | Train window open |
| rd_busy | output | 1 | Readout in progress |
| rd_pair | output | log2(NPAIR) | Pair under conversion |
| rd_ring | output | 1 | Ring under conversion (0 fast, 1 slow) |
| rd_addr | output | log2(DEPTH) | Slot under conversion |
| ramp_code | output | RW | Ramp counter value |
| conv_valid | output | 1 | Conversion result strobe |
| conv_code | output | RW | Conversion result |
| conv_pair | output | log2(NPAIR) | Pair of the result |
| conv_ring | output | 1 | Ring of the result |
| conv_addr | output | log2(DEPTH) | Slot of the result |
| rd_done | output | 1 | Readout finished |

## Verification
Several properties are checked on every cycle:
- a pointer wraps and holds correctly;
- hits appear only inside the train window and never twice in a row;
- the frozen count steps once per accepted hit;
- overflow is sticky and keeps the write strobes off;
- the ramp climbs by one per cycle;
- a result appears only as the ramp restarts.

Other behaviour needs the bench's scenarios to show it:
- the threshold boundary and the re-arm rule;
- the pointer values a pair records;
- the oldest-first address order;
- the first-crossing and full-scale codes;
- the exact result timing;
- a train start ignored during readout;
- the empty readout.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
  localparam logic RING_FAST = 1'b0;
  localparam logic RING_SLOW = 1'b1;
endpackage

// File: rtl/pstore_ring_ptr.sv
module pstore_ring_ptr #(
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_next
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] next_slot(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clr)       ptr_next = '0;
    else if (step) ptr_next = next_slot(ptr);
    else           ptr_next = ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ptr == LAST) |=> (ptr == '0)); // R2
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(ptr)); // R2
endmodule

// File: rtl/pstore_trig.sv
module pstore_trig #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm,
  input  logic          enable,
  input  logic          sample,
  input  logic [VW-1:0] v_lo,
  input  logic [VW-1:0] v_mid,
  input  logic [VW-1:0] v_hi,
  input  logic [VW+1:0] limit,
  output logic          fire
);
  logic armed;
  logic above;

  function automatic logic [VW+1:0] sum3(input logic [VW-1:0] a,
                                         input logic [VW-1:0] b,
                                         input logic [VW-1:0] c);
    return {2'b00, a} + {2'b00, b} + {2'b00, c};
  endfunction

  assign above = sum3(v_lo, v_mid, v_hi) > limit;
  assign fire  = enable && sample && above && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b1;
    else if (rearm)            armed <= 1'b1;
    else if (enable && sample) armed <= !above;
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rearm) |=> !fire); // R4
endmodule

// File: rtl/pstore_pair_alloc.sv
module pstore_pair_alloc #(
  parameter int NP = 4,
  parameter int AW = 4,
  parameter int PW = $clog2(NP),
  parameter int CW = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fire,
  input  logic [AW-1:0] snap_f,
  input  logic [AW-1:0] snap_s,
  input  logic [PW-1:0] rd_sel,
  output logic [CW-1:0] n_frozen,
  output logic          act_valid,
  output logic [PW-1:0] act_pair,
  output logic          overflow,
  output logic [AW-1:0] rd_f,
  output logic [AW-1:0] rd_s
);
  localparam logic [CW-1:0] FULL_CNT = CW'(NP);

  logic          accept;
  logic          drop;
  logic [AW-1:0] frz_f [NP];
  logic [AW-1:0] frz_s [NP];

  assign act_valid = n_frozen < FULL_CNT;
  assign act_pair  = act_valid ? PW'(n_frozen) : PW'(NP - 1);
  assign accept    = fire && act_valid && !clr;
  assign drop      = fire && !act_valid && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_frozen <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      n_frozen <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) n_frozen <= n_frozen + 1'b1;
      if (drop)   overflow <= 1'b1;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frz_f[g] <= '0;
        frz_s[g] <= '0;
      end else if (accept && n_frozen == CW'(g)) begin
        frz_f[g] <= snap_f;
        frz_s[g] <= snap_s;
      end
    end
  end

  assign rd_f = frz_f[rd_sel];
  assign rd_s = frz_s[rd_sel];

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow); // R6
  AST_FREEZE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (n_frozen == $past(n_frozen) + 1'b1)); // R5
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> !act_valid); // R6
endmodule

// File: rtl/pstore_conv_seq.sv
module pstore_conv_seq
  import pstore_pkg::*;
#(
  parameter int NP = 4,
  parameter int DEPTH = 16,
  parameter int RW = 10,
  parameter int AW = $clog2(DEPTH),
  parameter int PW = $clog2(NP),
  parameter int CW = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] n_frozen,
  input  logic [AW-1:0] base_f,
  input  logic [AW-1:0] base_s,
  input  logic          cmp_hit,
  output logic          busy,
  output logic [PW-1:0] rd_pair,
  output logic          rd_ring,
  output logic [AW-1:0] rd_addr,
  output logic [RW-1:0] ramp,
  output logic          conv_valid,
  output logic [RW-1:0] conv_code,
  output logic [PW-1:0] conv_pair,
  output logic          conv_ring,
  output logic [AW-1:0] conv_addr,
  output logic          done
);
  localparam logic [RW-1:0] FULL    = '1;
  localparam logic [AW-1:0] LAST_K  = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_X = (AW + 1)'(DEPTH);

  logic [AW-1:0] k;
  logic          got;
  logic [RW-1:0] held;
  logic          last_pair;

  function automatic logic [AW-1:0] unwrap(input logic [AW-1:0] base,
                                           input logic [AW-1:0] idx);
    logic [AW:0] s;
    s = {1'b0, base} + {1'b0, idx};
    if (s >= DEPTH_X) s = s - DEPTH_X;
    return s[AW-1:0];
  endfunction

  function automatic logic [RW-1:0] result(input logic seen, input logic [RW-1:0] at);
    return seen ? at : FULL;
  endfunction

  assign rd_addr   = unwrap((rd_ring == RING_SLOW) ? base_s : base_f, k);
  assign last_pair = (CW'(rd_pair) + CW'(1)) == n_frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rd_pair <= '0; rd_ring <= RING_FAST; k <= '0;
      ramp <= '0; got <= 1'b0; held <= '0;
      conv_valid <= 1'b0; conv_code <= '0; conv_pair <= '0;
      conv_ring <= RING_FAST; conv_addr <= '0; done <= 1'b0;
    end else begin
      conv_valid <= 1'b0;
      done       <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (n_frozen == '0) begin
            done <= 1'b1;
          end else begin
            busy <= 1'b1; rd_pair <= '0; rd_ring <= RING_FAST;
            k <= '0; ramp <= '0; got <= 1'b0;
          end
        end
      end else begin
        if (cmp_hit && !got) begin
          got  <= 1'b1;
          held <= ramp;
        end
        if (ramp == FULL) begin
          conv_valid <= 1'b1;
          conv_code  <= result(got, held);
          conv_pair  <= rd_pair;
          conv_ring  <= rd_ring;
          conv_addr  <= rd_addr;
          got        <= 1'b0;
          ramp       <= '0;
          if (k == LAST_K) begin
            k <= '0;
            if (rd_ring == RING_SLOW) begin
              rd_ring <= RING_FAST;
              if (last_pair) begin
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                rd_pair <= rd_pair + 1'b1;
              end
            end else begin
              rd_ring <= RING_SLOW;
            end
          end else begin
            k <= k + 1'b1;
          end
        end else begin
          ramp <= ramp + 1'b1;
        end
      end
    end
  end

  AST_RAMP_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ramp != FULL) |=> (ramp == RW'($past(ramp) + 1'b1))); // R9
  AST_RESULT_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> (ramp == '0)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: rtl/pulse_store_ctrl.sv
module pulse_store_ctrl #(
  parameter int DEPTH = 16,
  parameter int NPAIR = 4,
  parameter int VW = 10,
  parameter int RW = 10,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(NPAIR),
  localparam int CW = $clog2(NPAIR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          train_start,
  input  logic          train_end,
  input  logic          fast_tick,
  input  logic          slow_tick,
  input  logic [VW-1:0] nb_lo,
  input  logic [VW-1:0] own_val,
  input  logic [VW-1:0] nb_hi,
  input  logic [VW+1:0] thresh,
  input  logic          cmp_out,
  output logic [AW-1:0] fast_wptr,
  output logic [AW-1:0] slow_wptr,
  output logic          fast_we,
  output logic          slow_we,
  output logic [PW-1:0] wr_pair,
  output logic          overflow,
  output logic          acquiring,
  output logic          rd_busy,
  output logic [PW-1:0] rd_pair,
  output logic          rd_ring,
  output logic [AW-1:0] rd_addr,
  output logic [RW-1:0] ramp_code,
  output logic          conv_valid,
  output logic [RW-1:0] conv_code,
  output logic [PW-1:0] conv_pair,
  output logic          conv_ring,
  output logic [AW-1:0] conv_addr,
  output logic          rd_done
);
  logic          in_train;
  logic          start_ok;
  logic          end_ok;
  logic          fast_step;
  logic          slow_step;
  logic [AW-1:0] fptr_nx;
  logic [AW-1:0] sptr_nx;
  logic          trig_fire;
  logic          act_valid;
  logic [CW-1:0] n_frozen;
  logic [AW-1:0] base_f;
  logic [AW-1:0] base_s;

  assign start_ok  = train_start && !rd_busy;
  assign end_ok    = train_end && in_train && !train_start;
  assign fast_step = in_train && fast_tick;
  assign slow_step = in_train && slow_tick;
  assign acquiring = in_train;
  assign fast_we   = fast_step && act_valid;
  assign slow_we   = slow_step && act_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_train <= 1'b0;
    else if (start_ok) in_train <= 1'b1;
    else if (end_ok)   in_train <= 1'b0;
  end

  pstore_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_fast_ptr (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .step(fast_step),
    .ptr(fast_wptr), .ptr_next(fptr_nx));

  pstore_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_slow_ptr (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .step(slow_step),
    .ptr(slow_wptr), .ptr_next(sptr_nx));

  pstore_trig #(.VW(VW)) u_trig (
    .clk(clk), .rst_n(rst_n), .rearm(start_ok), .enable(in_train),
    .sample(slow_tick), .v_lo(nb_lo), .v_mid(own_val), .v_hi(nb_hi),
    .limit(thresh), .fire(trig_fire));

  pstore_pair_alloc #(.NP(NPAIR), .AW(AW), .PW(PW), .CW(CW)) u_alloc (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .fire(trig_fire),
    .snap_f(fptr_nx), .snap_s(sptr_nx), .rd_sel(rd_pair),
    .n_frozen(n_frozen), .act_valid(act_valid), .act_pair(wr_pair),
    .overflow(overflow), .rd_f(base_f), .rd_s(base_s));

  pstore_conv_seq #(.NP(NPAIR), .DEPTH(DEPTH), .RW(RW), .AW(AW), .PW(PW), .CW(CW)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(end_ok), .n_frozen(n_frozen),
    .base_f(base_f), .base_s(base_s), .cmp_hit(cmp_out),
    .busy(rd_busy), .rd_pair(rd_pair), .rd_ring(rd_ring), .rd_addr(rd_addr),
    .ramp(ramp_code), .conv_valid(conv_valid), .conv_code(conv_code),
    .conv_pair(conv_pair), .conv_ring(conv_ring), .conv_addr(conv_addr),
    .done(rd_done));

  AST_TRIG_IN_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |-> in_train); // R7
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !(fast_we || slow_we)); // R6
  AST_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> !in_train); // R8
endmodule

// File: tb/pulse_store_ctrl_test.sv
module pulse_store_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int NP = 4;
  localparam int VW = 6;
  localparam int RW = 5;
  localparam int AW = 4;
  localparam int PW = 2;
  localparam int MAXC = (1 << RW) - 1;
  localparam int CONV_LEN = 1 << RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_start = 1'b0, train_end = 1'b0, fast_tick = 1'b0, slow_tick = 1'b0;
  logic [VW-1:0] nb_lo = '0, own_val = '0, nb_hi = '0;
  logic [VW+1:0] thresh = '0;
  logic cmp_out;
  logic [AW-1:0] fast_wptr, slow_wptr, rd_addr, conv_addr;
  logic fast_we, slow_we, overflow, acquiring, rd_busy, rd_ring, conv_valid, conv_ring, rd_done;
  logic [PW-1:0] wr_pair, rd_pair, conv_pair;
  logic [RW-1:0] ramp_code, conv_code;

  int checks = 0;
  int errors = 0;
  int m_train = 0, m_f = 0, m_s = 0, m_armed = 1, m_nfz = 0, m_ovf = 0, thr_i = 0;
  int frz_f [NP];
  int frz_s [NP];

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int tgt(input int p, input int r, input int a);
    return (p * 37 + r * 11 + a * 5) % 40;
  endfunction

  assign cmp_out = rd_busy && (int'(ramp_code) >= tgt(int'(rd_pair), int'(rd_ring), int'(rd_addr)));

  pulse_store_ctrl #(.DEPTH(DEPTH), .NPAIR(NP), .VW(VW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .nb_lo(nb_lo), .own_val(own_val),
    .nb_hi(nb_hi), .thresh(thresh), .cmp_out(cmp_out),
    .fast_wptr(fast_wptr), .slow_wptr(slow_wptr), .fast_we(fast_we), .slow_we(slow_we),
    .wr_pair(wr_pair), .overflow(overflow), .acquiring(acquiring), .rd_busy(rd_busy),
    .rd_pair(rd_pair), .rd_ring(rd_ring), .rd_addr(rd_addr), .ramp_code(ramp_code),
    .conv_valid(conv_valid), .conv_code(conv_code), .conv_pair(conv_pair),
    .conv_ring(conv_ring), .conv_addr(conv_addr), .rd_done(rd_done));

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R2", int'(fast_wptr), m_f, "fast pointer");
    chk("R2", int'(slow_wptr), m_s, "slow pointer");
    if (m_nfz < NP) chk("R5", int'(wr_pair), m_nfz, "active pair");
    chk("R6", int'(overflow), m_ovf, "overflow flag");
    chk("R1", int'(acquiring), m_train, "acquiring");
  endtask

  task automatic step(input bit ft, input bit st, input int l, input int c, input int r);
    int sum;
    bit above;
    bit fire;
    @(negedge clk);
    fast_tick = ft; slow_tick = st;
    nb_lo = VW'(l); own_val = VW'(c); nb_hi = VW'(r); thresh = (VW + 2)'(thr_i);
    #1;
    chk(m_nfz == NP ? "R6" : "R2", int'(fast_we), (m_train != 0 && ft && m_nfz < NP) ? 1 : 0, "fast strobe");
    chk(m_nfz == NP ? "R6" : "R2", int'(slow_we), (m_train != 0 && st && m_nfz < NP) ? 1 : 0, "slow strobe");
    @(posedge clk);
    #2;
    sum = l + c + r;
    above = sum > thr_i;
    if (m_train != 0) begin
      fire = st && above && (m_armed != 0);
      if (st) m_armed = above ? 0 : 1;
      if (ft) m_f = (m_f + 1) % DEPTH;
      if (st) m_s = (m_s + 1) % DEPTH;
      if (fire) begin
        if (m_nfz < NP) begin
          frz_f[m_nfz] = m_f;
          frz_s[m_nfz] = m_s;
          m_nfz++;
        end else begin
          m_ovf = 1;
        end
      end
    end
    check_state();
    fast_tick = 0; slow_tick = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    train_start = 1;
    @(posedge clk);
    #2;
    train_start = 0;
    m_train = 1; m_f = 0; m_s = 0; m_armed = 1; m_nfz = 0; m_ovf = 0;
    check_state();
  endtask

  task automatic readout();
    int j;
    int p, rg, kk, base, a, t, ec;
    int limit;
    @(negedge clk);
    train_end = 1;
    @(posedge clk);
    #2;
    train_end = 0;
    m_train = 0;
    if (m_nfz == 0) begin
      chk("R10", int'(rd_done), 1, "done for empty readout");
      chk("R10", int'(rd_busy), 0, "no readout when empty");
      return;
    end
    j = 0;
    limit = m_nfz * 2 * DEPTH * CONV_LEN + 4;
    for (int c = 1; c <= limit; c++) begin
      if (c == 40) train_start = 1;
      if (c == 41) train_start = 0;
      @(posedge clk);
      #2;
      if (c == 45) begin
        chk("R1", int'(acquiring), 0, "start ignored while reading");
        chk("R1", int'(overflow), m_ovf, "overflow kept while reading");
      end
      if (conv_valid) begin
        p = j / (2 * DEPTH);
        rg = (j / DEPTH) % 2;
        kk = j % DEPTH;
        base = (rg != 0) ? frz_s[p] : frz_f[p];
        a = (base + kk) % DEPTH;
        t = tgt(p, rg, a);
        ec = (t > MAXC) ? MAXC : t;
        chk("R10", c, CONV_LEN * (j + 1), "result cycle");
        chk("R8", int'(conv_pair), p, "result pair");
        chk("R8", int'(conv_ring), rg, "result ring");
        chk("R8", int'(conv_addr), a, "oldest-first slot");
        chk("R9", int'(conv_code), ec, "conversion code");
        j++;
      end
      if (rd_done) begin
        chk("R10", int'(conv_valid), 1, "done with last result");
        break;
      end
    end
    chk("R10", j, m_nfz * 2 * DEPTH, "result count");
    chk("R10", int'(rd_busy), 0, "idle after readout");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(fast_wptr), 0, "reset fast pointer");
    chk("R1", int'(slow_wptr), 0, "reset slow pointer");
    chk("R1", int'(wr_pair), 0, "reset pair");
    chk("R1", int'(overflow), 0, "reset overflow");
    chk("R1", int'(acquiring), 0, "reset acquiring");
    chk("R1", int'(rd_busy), 0, "reset busy");
    @(negedge clk);
    rst_n = 1;

    // R7: outside the train nothing moves
    thr_i = 30;
    repeat (6) step(1, 1, 40, 40, 40);
    chk("R7", int'(wr_pair), 0, "hit outside train");
    chk("R7", int'(fast_wptr), 0, "tick outside train");

    pulse_start();
    for (int i = 0; i < 40; i++) step(1, (i % 4) == 3, 1, 2, 3);

    // R3: threshold boundary
    step(0, 1, 10, 10, 10);
    chk("R3", int'(wr_pair), 0, "sum equal threshold");
    step(1, 1, 10, 10, 11);
    chk("R3", int'(wr_pair), 1, "sum above threshold");
    // R4: no refire while above
    step(1, 1, 20, 20, 20);
    step(1, 0, 0, 0, 0);
    step(1, 1, 63, 63, 63);
    chk("R4", int'(wr_pair), 1, "held above, no refire");
    step(1, 1, 0, 0, 0);
    step(1, 0, 50, 50, 50);
    chk("R3", int'(wr_pair), 1, "no slow tick, no hit");
    step(1, 1, 50, 0, 0);
    chk("R4", int'(wr_pair), 2, "rearmed hit");

    for (int t = 0; t < 3; t++) begin
      repeat (t + 2) step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(1, 1, 31, 0, 0);
    end
    chk("R6", int'(overflow), 1, "hit with all pairs frozen");
    step(1, 1, 0, 0, 0);
    readout();

    pulse_start();
    chk("R6", int'(overflow), 0, "overflow cleared by start");
    chk("R1", int'(wr_pair), 0, "pairs freed by start");
    for (int i = 0; i < 23; i++) step((i % 3) != 0, (i % 5) == 4, 0, 0, 0);
    step(1, 1, 0, 0, 40);
    chk("R5", int'(wr_pair), 1, "second train hit");
    repeat (5) step(1, 0, 0, 0, 0);
    readout();

    pulse_start();
    repeat (7) step(1, 1, 1, 1, 1);
    readout();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule